// File: doc/BRIEF.md
# Multi-Cycle Phase Detector

This block follows the phase relation between a reference clock and a PLL feedback clock. Both clocks reach it as one-cycle edge strobes in the system clock domain. A signed accumulator counts reference edges minus feedback edges, so the block remembers how many whole cycles the feedback is ahead of or behind the reference. That count can span thousands of cycles, inside a window set by a range code. The block appends an externally measured 8-bit fine fraction to the cycle count and passes the result to a digital loop filter as a signed phase error. In the fraction, one cycle equals 256 LSB.

A loop-use select chooses what the filter sees. It gets either the full multi-cycle error or an error clipped to one cycle of magnitude. The full count is kept internally in both cases. The same window also serves as a coarse cycle-slip detector: a loss flag is raised while the accumulated count sits at the window edge. When tracking is disabled, the block acts as a plain single-cycle detector.

Top module: `cyc_phase_det`

## Requirements
- R1: While `mc_en` is low, the accumulator is confined to the range −1..+1 cycles and `loss` reads 0 one cycle later.
- R2: While `mc_en` is high, range code k gives a window of ±(2^(k+1)−1) cycles. Any code above 12 acts as 12, which gives ±8191.
- R3: A reference strobe alone adds one to the accumulator. A feedback strobe alone subtracts one. The new count is visible on `phase_err` in the cycle after the strobe.
- R4: The accumulator saturates at the window edge and never wraps.
- R5: With `loop_full` high, `phase_err` equals accumulator × 256 + `frac`, in two's complement, with the cycle count in the upper bits and `frac` in bits [7:0].
- R6: With `loop_full` low, `phase_err` is limited to −256..+256. A count of +1 or more gives +256. A count of −2 or less gives −256. Otherwise the R5 value is output. The stored count is unchanged, so raising `loop_full` again reveals the full count.
- R7: `loss` is registered. It is 1 exactly when, after the update, `mc_en` is high and the count magnitude equals or exceeds the window limit. It clears once the magnitude falls below the limit.
- R8: A reference strobe and a feedback strobe in the same cycle cancel, and the count is unchanged.
- R9: `clr` zeroes the accumulator and `loss` on the next edge. It takes priority over strobes.
- R10: After reset the count is 0 and `loss` is 0.
- R11: If the window shrinks below the current count, the count is pulled to the new window edge on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the count and the loss flag |
| mc_en | input | 1 | Multi-cycle tracking enable |
| range_code | input | 4 | Window code k |
| loop_full | input | 1 | 1: full error to the loop; 0: one-cycle clip |
| ref_edge | input | 1 | Reference edge strobe |
| fb_edge | input | 1 | Feedback edge strobe |
| frac | input | 8 | Fine phase fraction within the input period |
| phase_err | output | 23 | Signed phase error {cycles, fraction} |
| loss | output | 1 | Coarse phase loss flag |

## Verification
The properties assume each strobe is a single system-clock pulse per clock edge, and that `frac` is a plain unsigned position within one period. They place no requirement on how often the range code changes. The step and cancel properties therefore apply only when the count already lies inside the current window. The stimulus draws strobes and fractions freely from a fixed seed. It changes the range code rarely and biases it toward small codes, so that saturation, window shrinking and loss transitions come up often. Directed runs push the count to ±8191 and exercise the clip at both signs.

// File: rtl/cyc_phase_det.sv
module cyc_phase_det #(
  parameter int FRAC_W   = 8,
  parameter int CNT_W    = 15,
  parameter int MAX_CODE = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic                            mc_en,
  input  logic [3:0]                      range_code,
  input  logic                            loop_full,
  input  logic                            ref_edge,
  input  logic                            fb_edge,
  input  logic [FRAC_W-1:0]               frac,
  output logic signed [CNT_W+FRAC_W-1:0]  phase_err,
  output logic                            loss
);
  localparam int OUT_W = CNT_W + FRAC_W;
  localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic signed [OUT_W-1:0] POS_CAP = OUT_W'(1) << FRAC_W;
  localparam logic signed [OUT_W-1:0] NEG_CAP = -POS_CAP;

  logic signed [CNT_W-1:0] acc, lim, win, sum, nxt;
  logic [3:0] ksat;
  logic       up, dn, loss_d;

  assign ksat = (range_code > 4'(MAX_CODE)) ? 4'(MAX_CODE) : range_code;
  assign lim  = (ONE <<< (ksat + 4'd1)) - ONE;
  assign win  = mc_en ? lim : ONE;

  assign up  = ref_edge & ~fb_edge;
  assign dn  = fb_edge & ~ref_edge;
  assign sum = acc + (up ? ONE : '0) - (dn ? ONE : '0);
  assign nxt = (sum > win) ? win : ((sum < -win) ? -win : sum);

  assign loss_d = mc_en && (nxt >= lim || nxt <= -lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      loss <= 1'b0;
    end else if (clr) begin
      acc  <= '0;
      loss <= 1'b0;
    end else begin
      acc  <= nxt;
      loss <= loss_d;
    end
  end

  logic signed [OUT_W-1:0] raw;
  assign raw = {acc, frac};

  always_comb begin
    if (loop_full)         phase_err = raw;
    else if (acc >= ONE)   phase_err = POS_CAP;
    else if (acc < -ONE)   phase_err = NEG_CAP;
    else                   phase_err = raw;
  end
endmodule

// File: rtl/cyc_phase_det_chk.sv
module cyc_phase_det_chk #(
  parameter int FRAC_W = 8,
  parameter int CNT_W  = 15
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           clr,
  input logic                           mc_en,
  input logic                           loop_full,
  input logic                           ref_edge,
  input logic                           fb_edge,
  input logic signed [CNT_W+FRAC_W-1:0] phase_err,
  input logic                           loss,
  input logic signed [CNT_W-1:0]        acc,
  input logic signed [CNT_W-1:0]        lim
);
  localparam int OUT_W = CNT_W + FRAC_W;
  localparam logic signed [OUT_W-1:0] CAP = OUT_W'(1) << FRAC_W;
  localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);

  // R6
  clip_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_full |-> (phase_err <= CAP && phase_err >= -CAP));

  // R8
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_edge && fb_edge && !clr && mc_en && acc <= lim && acc >= -lim)
    |=> acc == $past(acc));

  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_edge && !fb_edge && !clr && mc_en && acc < lim && acc >= -lim)
    |=> acc == $past(acc) + ONE);

  // R1
  off_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mc_en && !clr) |=> (acc <= ONE && acc >= -ONE && !loss));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0 && !loss));

  // R7
  loss_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && mc_en && !ref_edge && !fb_edge && (acc >= lim || acc <= -lim))
    |=> loss);
endmodule

bind cyc_phase_det cyc_phase_det_chk #(.FRAC_W(FRAC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .mc_en(mc_en), .loop_full(loop_full),
  .ref_edge(ref_edge), .fb_edge(fb_edge), .phase_err(phase_err), .loss(loss),
  .acc(acc), .lim(lim)
);

// File: tb/cyc_phase_det_tb.sv
module cyc_phase_det_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, mc_en = 1'b1, loop_full = 1'b1;
  logic ref_edge = 1'b0, fb_edge = 1'b0;
  logic [3:0] range_code = 4'd0;
  logic [7:0] frac = 8'd0;
  logic signed [22:0] phase_err;
  logic loss;

  int tests = 0, fails = 0;
  int m_acc = 0;
  bit m_loss = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cyc_phase_det u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mc_en(mc_en), .range_code(range_code),
    .loop_full(loop_full), .ref_edge(ref_edge), .fb_edge(fb_edge), .frac(frac),
    .phase_err(phase_err), .loss(loss)
  );

  function automatic int lim_of(input int k);
    int kk = (k > 12) ? 12 : k;
    return (1 << (kk + 1)) - 1;
  endfunction

  function automatic int exp_err(input int a, input int f, input bit full);
    if (full) return a * 256 + f;
    if (a >= 1) return 256;
    if (a <= -2) return -256;
    return a * 256 + f;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input bit r, input bit f, input bit c);
    int w, lm, d;
    ref_edge = r; fb_edge = f; clr = c;
    @(posedge clk);
    lm = lim_of(range_code);
    w  = mc_en ? lm : 1;
    d  = (r && !f) ? 1 : ((f && !r) ? -1 : 0);
    if (c) begin
      m_acc = 0; m_loss = 1'b0;
    end else begin
      m_acc = m_acc + d;
      if (m_acc > w) m_acc = w;
      if (m_acc < -w) m_acc = -w;
      m_loss = mc_en && (m_acc >= lm || m_acc <= -lm);
    end
    @(negedge clk);
    check({tag, " err"}, int'(phase_err), exp_err(m_acc, frac, loop_full));
    check({tag, " loss"}, int'(loss), int'(m_loss));
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog actual running expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h51ab_c0de));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    frac = 8'h3c;
    @(negedge clk);
    check("R10 reset err", int'(phase_err), 8'h3c);
    check("R10 reset loss", int'(loss), 0);

    // R2 / R4: code 0 window is +-1
    range_code = 4'd0;
    repeat (3) cyc("R4 code0", 1, 0, 0);
    check("R2 code0 sat", int'(phase_err), 256 + 8'h3c);
    repeat (5) cyc("R4 code0 neg", 0, 1, 0);
    check("R2 code0 loss", int'(loss), 1);

    // R8 cancel
    cyc("R9 clear", 1, 0, 1);
    range_code = 4'd3;
    repeat (4) cyc("R3 up", 1, 0, 0);
    repeat (6) cyc("R8 cancel", 1, 1, 0);
    check("R8 held", int'(phase_err), 4 * 256 + 8'h3c);

    // R11 shrink
    range_code = 4'd5;
    repeat (70) cyc("R4 code5", 1, 0, 0);
    check("R7 loss at 63", int'(loss), 1);
    range_code = 4'd2;
    cyc("R11 shrink", 0, 0, 0);
    check("R11 to 7", int'(phase_err), 7 * 256 + 8'h3c);
    cyc("R7 clear below", 0, 1, 0);
    check("R7 loss off", int'(loss), 0);

    // R6 clip, R5 full restore
    loop_full = 1'b0;
    cyc("R6 pos", 0, 0, 0);
    check("R6 cap pos", int'(phase_err), 256);
    loop_full = 1'b1;
    cyc("R5 restore", 0, 0, 0);
    check("R5 full", int'(phase_err), 6 * 256 + 8'h3c);
    loop_full = 1'b0;
    repeat (9) cyc("R6 down", 0, 1, 0);
    check("R6 cap neg", int'(phase_err), -256);
    frac = 8'h80;
    cyc("R9 clr prio", 0, 1, 1);
    cyc("R6 minus1", 0, 1, 0);
    check("R6 -1 pass", int'(phase_err), -256 + 128);

    // R2: code above 12 reaches 8191
    loop_full = 1'b1;
    range_code = 4'd15;
    cyc("R9 clear", 0, 0, 1);
    repeat (8200) cyc("R2 ramp", 1, 0, 0);
    check("R2 8191", int'(phase_err), 8191 * 256 + 8'h80);
    repeat (16400) cyc("R4 ramp neg", 0, 1, 0);
    check("R4 -8191", int'(phase_err), -8191 * 256 + 8'h80);

    // R1 disabled
    mc_en = 1'b0;
    cyc("R1 off", 0, 0, 0);
    check("R1 pulled", int'(phase_err), -256 + 8'h80);
    check("R1 loss", int'(loss), 0);
    repeat (4) cyc("R1 off up", 1, 0, 0);

    // random
    for (int i = 0; i < 6000; i++) begin
      bit r, f, c;
      if ($urandom_range(0, 49) == 0)
        range_code = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'($urandom_range(0, 3));
      if ($urandom_range(0, 99) == 0) mc_en = ($urandom_range(0, 4) != 0);
      if ($urandom_range(0, 19) == 0) loop_full = 1'($urandom_range(0, 1));
      frac = 8'($urandom_range(0, 255));
      r = 1'($urandom_range(0, 1));
      f = 1'($urandom_range(0, 1));
      c = ($urandom_range(0, 199) == 0);
      cyc("R3 R7 rand", r, f, c);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule